// File: doc/BRIEF.md
# Cache Line Refill Sequencer

This block fetches one whole cache line from main memory after a cache miss. A one-cycle request carries a word address. The block aligns that address down to a line boundary and spends one bus cycle presenting it to memory. It then waits out the DRAM access time and collects the words of the line in increasing offset order. When the last word has arrived, it raises a one-cycle completion flag. At the same moment it presents the assembled line and the exact number of bus cycles the refill took.

A parameter chooses one of three memory organisations, and this choice sets the refill timing. With a bus one word wide, every word costs a full access plus one transfer cycle. With a bus several words wide, each access returns a group of words in a single transfer. With interleaved banks, one access starts every bank at the same time, and the banks then hand back their words on successive cycles. Line length, bus width, bank count and access latency are all parameters. The block reports the resulting miss penalty so the cache side can account for it.

Top module: `refill_seq`

## Requirements
- R1: After reset, busy and done are low, cycles is zero and every bit of line is zero.
- R2: In the first cycle after an accepted request, mem_addr_valid is high for exactly one cycle. In that cycle mem_addr carries the request address with its low log2(LINE_WORDS) bits cleared.
- R3: With the one-word organisation, a refill occupies 1 + LINE_WORDS×(ACCESS_LAT+1) cycles. For 4 words and a latency of 15, that is 65.
- R4: With the wide organisation, a refill occupies 1 + (LINE_WORDS/BUS_WORDS)×(ACCESS_LAT+1) cycles. For 4 words on a 4-word bus, that is 17.
- R5: With the interleaved organisation, a refill occupies 1 + (LINE_WORDS/BANKS)×(ACCESS_LAT+BANKS) cycles. This gives 20 for a 4-word line and 39 for an 8-word line, both with 4 banks.
- R6: In each cycle with mem_rd_en high, lane k of mem_rdata (bits k×WORD_W upward) is the memory word at mem_rd_addr+k. mem_rd_addr rises through the line in offset order. After done, word w of line (bits w×WORD_W upward) holds the memory word at the aligned base plus w.
- R7: busy goes high in the cycle after an accepted request and stays high until the last transfer. done is then high for exactly one cycle, and busy is low in that cycle.
- R8: In the cycle done is high, cycles equals the number of cycles busy was high for that refill. cycles holds this value until the next completion.
- R9: A request that arrives while busy is high is ignored. The running refill keeps its address, its timing and its single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Miss request, accepted when idle |
| req_addr | input | ADDR_W | Word address of the missing word |
| busy | output | 1 | Refill in progress |
| done | output | 1 | One-cycle completion flag |
| cycles | output | CYC_W | Bus cycles spent on the last refill |
| line | output | LINE_WORDS×WORD_W | Assembled line, word 0 in the low bits |
| mem_addr_valid | output | 1 | Address phase to memory |
| mem_addr | output | ADDR_W | Line-aligned word address |
| mem_rd_en | output | 1 | Transfer cycle, mem_rdata is captured |
| mem_rd_addr | output | ADDR_W | Word address of lane 0 in this transfer |
| mem_rdata | input | WPX×WORD_W | Words returned by memory, WPX being BUS_WORDS on the wide bus and 1 otherwise |

## Verification
Some properties are checked on every cycle, whatever the traffic:
- the address phase is one cycle long, aligned, and only follows an accepted request;
- done is a single-cycle pulse that never coincides with busy;
- the memory side stays quiet while idle;
- transfer addresses step upward by the bus width;
- the reported count always matches a busy-cycle tally kept apart from the design.

Other behaviour only the bench scenarios can show:
- the exact penalty of each organisation, run side by side on four configurations;
- the contents of the assembled line against a computed memory image;
- alignment of unaligned and top-of-space addresses;
- that a request injected mid-refill changes neither the line nor the timing.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ORG_NARROW      = 2'd0,
    ORG_WIDE        = 2'd1,
    ORG_INTERLEAVED = 2'd2
  } mem_org_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_XFER = 2'd3
  } refill_st_e;

  // words that one DRAM access makes available
  function automatic int words_per_access(mem_org_e org, int bus_words, int banks);
    case (org)
      ORG_WIDE:        return bus_words;
      ORG_INTERLEAVED: return banks;
      default:         return 1;
    endcase
  endfunction

  // words moved in one transfer cycle
  function automatic int words_per_beat(mem_org_e org, int bus_words);
    return (org == ORG_WIDE) ? bus_words : 1;
  endfunction

endpackage

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 4,
  parameter int WPA        = 1,
  parameter int WPX        = 1,
  parameter int ACCESS_LAT = 15,
  parameter int CYC_W      = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          busy,
  output logic                          done,
  output logic [CYC_W-1:0]              cycles,
  output logic                          mem_addr_valid,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic                          mem_rd_en,
  output logic [ADDR_W-1:0]             mem_rd_addr,
  output logic [$clog2(LINE_WORDS)-1:0] wr_idx
);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int BEATS  = WPA / WPX;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int WAIT_W = (ACCESS_LAT > 1) ? $clog2(ACCESS_LAT) : 1;

  refill_st_e        st;
  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  idx;
  logic [BEAT_W-1:0] beat;
  logic [WAIT_W-1:0] wcnt;
  logic [CYC_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      base_q <= '0;
      idx    <= '0;
      beat   <= '0;
      wcnt   <= '0;
      cnt    <= '0;
      done   <= 1'b0;
      cycles <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req) begin
            st     <= ST_ADDR;
            base_q <= req_addr & ~ADDR_W'(LINE_WORDS - 1);
            idx    <= '0;
            beat   <= '0;
            cnt    <= '0;
          end
        end
        ST_ADDR: begin
          st   <= ST_WAIT;
          wcnt <= '0;
          cnt  <= cnt + CYC_W'(1);
        end
        ST_WAIT: begin
          cnt  <= cnt + CYC_W'(1);
          wcnt <= wcnt + WAIT_W'(1);
          if (wcnt == WAIT_W'(ACCESS_LAT - 1)) st <= ST_XFER;
        end
        ST_XFER: begin
          cnt <= cnt + CYC_W'(1);
          idx <= idx + OFF_W'(WPX);
          if (beat == BEAT_W'(BEATS - 1)) begin
            beat <= '0;
            wcnt <= '0;
            if (idx == OFF_W'(LINE_WORDS - WPX)) begin
              st     <= ST_IDLE;
              done   <= 1'b1;
              cycles <= cnt + CYC_W'(1);
            end else begin
              st <= ST_WAIT;
            end
          end else begin
            beat <= beat + BEAT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy           = (st != ST_IDLE);
  assign mem_addr_valid = (st == ST_ADDR);
  assign mem_addr       = base_q;
  assign mem_rd_en      = (st == ST_XFER);
  assign mem_rd_addr    = base_q | ADDR_W'(idx);
  assign wr_idx         = idx;

endmodule

// File: rtl/line_buf.sv
module line_buf #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int WPX        = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [$clog2(LINE_WORDS)-1:0] wr_idx,
  input  logic [WPX*WORD_W-1:0]         wr_data,
  output logic [LINE_WORDS*WORD_W-1:0]  line
);
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    localparam int LANE = w % WPX;
    localparam int SLOT = w / WPX;
    always_ff @(posedge clk) begin
      if (rst) begin
        line[w*WORD_W +: WORD_W] <= '0;
      end else if (wr_en && (int'(wr_idx) / WPX) == SLOT) begin
        line[w*WORD_W +: WORD_W] <= wr_data[LANE*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter int       ADDR_W     = 16,
  parameter int       WORD_W     = 32,
  parameter int       LINE_WORDS = 4,
  parameter mem_org_e ORG        = ORG_NARROW,
  parameter int       BUS_WORDS  = 4,
  parameter int       BANKS      = 4,
  parameter int       ACCESS_LAT = 15,
  parameter int       CYC_W      = 8,
  localparam int      WPA        = words_per_access(ORG, BUS_WORDS, BANKS),
  localparam int      WPX        = words_per_beat(ORG, BUS_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         busy,
  output logic                         done,
  output logic [CYC_W-1:0]             cycles,
  output logic [LINE_WORDS*WORD_W-1:0] line,
  output logic                         mem_addr_valid,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic                         mem_rd_en,
  output logic [ADDR_W-1:0]            mem_rd_addr,
  input  logic [WPX*WORD_W-1:0]        mem_rdata
);
  localparam int OFF_W = $clog2(LINE_WORDS);

  logic [OFF_W-1:0] wr_idx;

  refill_ctrl #(
    .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .WPA(WPA), .WPX(WPX),
    .ACCESS_LAT(ACCESS_LAT), .CYC_W(CYC_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr),
    .busy(busy), .done(done), .cycles(cycles),
    .mem_addr_valid(mem_addr_valid), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .wr_idx(wr_idx)
  );

  line_buf #(
    .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .WPX(WPX)
  ) u_buf (
    .clk(clk), .rst(rst), .wr_en(mem_rd_en), .wr_idx(wr_idx),
    .wr_data(mem_rdata), .line(line)
  );

endmodule

// File: rtl/refill_seq_chk.sv
module refill_seq_chk #(
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 4,
  parameter int WPX        = 1,
  parameter int CYC_W      = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              busy,
  input logic              done,
  input logic [CYC_W-1:0]  cycles,
  input logic              mem_addr_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr
);
  // independent tally of busy cycles for the current or last refill
  logic             busy_d;
  logic [CYC_W-1:0] run;
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_d <= 1'b0;
      run    <= '0;
    end else begin
      busy_d <= busy;
      if (busy) run <= busy_d ? run + CYC_W'(1) : CYC_W'(1);
    end
  end

  a_r2_addr_one_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_addr_valid |=> !mem_addr_valid);
  a_r2_addr_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_addr_valid |-> (mem_addr % LINE_WORDS) == 0);
  a_r2_addr_after_req: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> mem_addr_valid);
  a_r7_busy_after_req: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> busy);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd_en && !mem_addr_valid));
  a_r6_ascending: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(WPX));
  a_r8_count_match: assert property (@(posedge clk) disable iff (rst)
    done |-> cycles == run);
  a_r8_count_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(cycles));
endmodule

bind refill_seq refill_seq_chk #(
  .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .WPX(WPX), .CYC_W(CYC_W)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .busy(busy), .done(done), .cycles(cycles),
  .mem_addr_valid(mem_addr_valid), .mem_addr(mem_addr),
  .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr)
);

// File: tb/refill_seq_tb.sv
`timescale 1ns/1ps
module refill_seq_tb;
  import refill_pkg::*;

  localparam int LAT = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [15:0] req_addr = '0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  function automatic logic [31:0] memf(logic [15:0] a);
    return {a ^ 16'hA5C3, a + 16'h1357};
  endfunction

  // narrow, 4-word line
  logic n_busy, n_done, n_av, n_re; logic [7:0] n_cyc; logic [127:0] n_line;
  logic [15:0] n_ma, n_ra; logic [31:0] n_rd;
  assign n_rd = memf(n_ra);
  refill_seq #(.LINE_WORDS(4), .ORG(ORG_NARROW), .ACCESS_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .busy(n_busy), .done(n_done),
    .cycles(n_cyc), .line(n_line), .mem_addr_valid(n_av), .mem_addr(n_ma),
    .mem_rd_en(n_re), .mem_rd_addr(n_ra), .mem_rdata(n_rd));

  // wide bus of 4 words, 4-word line
  logic w_busy, w_done, w_av, w_re; logic [7:0] w_cyc; logic [127:0] w_line;
  logic [15:0] w_ma, w_ra; logic [127:0] w_rd;
  always_comb for (int k = 0; k < 4; k++) w_rd[k*32 +: 32] = memf(w_ra + 16'(k));
  refill_seq #(.LINE_WORDS(4), .ORG(ORG_WIDE), .BUS_WORDS(4), .ACCESS_LAT(LAT)) u_dut_wide (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .busy(w_busy), .done(w_done),
    .cycles(w_cyc), .line(w_line), .mem_addr_valid(w_av), .mem_addr(w_ma),
    .mem_rd_en(w_re), .mem_rd_addr(w_ra), .mem_rdata(w_rd));

  // 4 interleaved banks, 4-word line
  logic i_busy, i_done, i_av, i_re; logic [7:0] i_cyc; logic [127:0] i_line;
  logic [15:0] i_ma, i_ra; logic [31:0] i_rd;
  assign i_rd = memf(i_ra);
  refill_seq #(.LINE_WORDS(4), .ORG(ORG_INTERLEAVED), .BANKS(4), .ACCESS_LAT(LAT)) u_dut_ilv (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .busy(i_busy), .done(i_done),
    .cycles(i_cyc), .line(i_line), .mem_addr_valid(i_av), .mem_addr(i_ma),
    .mem_rd_en(i_re), .mem_rd_addr(i_ra), .mem_rdata(i_rd));

  // 4 interleaved banks, 8-word line (two access groups)
  logic j_busy, j_done, j_av, j_re; logic [7:0] j_cyc; logic [255:0] j_line;
  logic [15:0] j_ma, j_ra; logic [31:0] j_rd;
  assign j_rd = memf(j_ra);
  refill_seq #(.LINE_WORDS(8), .ORG(ORG_INTERLEAVED), .BANKS(4), .ACCESS_LAT(LAT)) u_dut_ilv8 (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .busy(j_busy), .done(j_done),
    .cycles(j_cyc), .line(j_line), .mem_addr_valid(j_av), .mem_addr(j_ma),
    .mem_rd_en(j_re), .mem_rd_addr(j_ra), .mem_rdata(j_rd));

  task automatic chk(bit ok, string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [255:0] exp_line(logic [15:0] a, int words);
    logic [255:0] v = '0;
    logic [15:0] base = a & ~16'(words - 1);
    for (int w = 0; w < words; w++) v[w*32 +: 32] = memf(base + 16'(w));
    return v;
  endfunction

  task automatic judge(string tag, string tag9, bit inj, int pen, int seen, int pulses,
                       int cyc, logic [255:0] got, logic [255:0] exp);
    chk(seen == pen, $sformatf("%s done cycle act=%0d exp=%0d", tag, seen, pen));
    chk(cyc == pen, $sformatf("R8 %s cycles act=%0d exp=%0d", tag, cyc, pen));
    chk(got == exp, $sformatf("R6 %s line act=%h exp=%h", tag, got, exp));
    chk(pulses == 1, $sformatf("%s done pulses act=%0d exp=1", inj ? tag9 : "R7", pulses));
  endtask

  task automatic run_one(logic [15:0] a, bit inj);
    int ns = -1, ws = -1, is = -1, js = -1;
    int np = 0, wp = 0, ip = 0, jp = 0;
    int nc = 0, wc = 0, ic = 0, jc = 0;
    logic [255:0] nl = '0, wl = '0, il = '0, jl = '0;
    @(negedge clk); req = 1'b1; req_addr = a;
    @(negedge clk); req = 1'b0;
    chk(n_av && j_av, $sformatf("R2 addr phase act=%b%b exp=11", n_av, j_av));
    chk(n_ma == (a & 16'hFFFC) && j_ma == (a & 16'hFFF8),
        $sformatf("R2 aligned act=%h/%h exp=%h/%h", n_ma, j_ma, a & 16'hFFFC, a & 16'hFFF8));
    chk(n_busy && w_busy && i_busy && j_busy, "R7 busy after request act=0 exp=1");
    for (int k = 1; k <= 100; k++) begin
      @(negedge clk);
      if (inj && k == 5) begin req = 1'b1; req_addr = a ^ 16'h0040; end
      if (k == 6) req = 1'b0;
      if (n_done) begin np++; if (ns < 0) begin ns = k; nc = n_cyc; nl = 256'(n_line); end end
      if (w_done) begin wp++; if (ws < 0) begin ws = k; wc = w_cyc; wl = 256'(w_line); end end
      if (i_done) begin ip++; if (is < 0) begin is = k; ic = i_cyc; il = 256'(i_line); end end
      if (j_done) begin jp++; if (js < 0) begin js = k; jc = j_cyc; jl = j_line; end end
    end
    judge("R3 narrow", "R9 narrow", inj, 1 + 4*(LAT+1), ns, np, nc, nl, exp_line(a, 4));
    judge("R4 wide", "R9 wide", inj, 1 + (4/4)*(LAT+1), ws, wp, wc, wl, exp_line(a, 4));
    judge("R5 ilv4", "R9 ilv4", inj, 1 + (4/4)*(LAT+4), is, ip, ic, il, exp_line(a, 4));
    judge("R5 ilv8", "R9 ilv8", inj, 1 + (8/4)*(LAT+4), js, jp, jc, jl, exp_line(a, 8));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!n_busy && !n_done && !w_busy && !i_busy && !j_busy, "R1 busy/done act=1 exp=0");
    chk(n_cyc == 0 && j_cyc == 0, $sformatf("R1 cycles act=%0d exp=0", n_cyc));
    chk(n_line == '0 && j_line == '0, $sformatf("R1 line act=%h exp=0", n_line));
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a;
      a = (i == 39) ? 16'hFFFF : 16'(i * 613 + i);
      run_one(a, (i % 3) == 1);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule